// File: doc/BRIEF.md
# Digital Automatic Gain Control Loop

This block closes a gain control loop around a stream of complex baseband samples. Each accepted I/Q pair is turned into a power figure, I² + Q², which is mapped to an approximate base-2 logarithm. The block can average one to four of these log estimates and then uses only one averaged estimate out of every N to update the loop. At each update it subtracts the measured level from a programmed target level. The difference drives a first-order recursion with a programmable pole and loop gain. The result is an 8-bit log-domain gain word that is clamped to its limits.

The gain word scales every sample on its way out. The integer part of the gain shifts the sample left. The fractional part, added to one, acts as a linear multiplier in place of the fractional power of two. The scaled result is clamped to 16 bits. A bypass control passes samples through unchanged and freezes the loop. A hold-off count keeps the first samples after reset out of the measurement, which lets the input settle before the loop reacts.

Top module: `agc_loop_ctrl`

## Requirements
- R1: The level estimate of a sample is 16·m + f. Here m is the bit position of the leading one of P = I² + Q² (32-bit unsigned), and f is the 4 bits just below that leading one. P = 0 gives 0. The estimate is a 9-bit unsigned value in log2 units with 4 fractional bits.
- R2: At each loop update the gain becomes clamp(floor((pole·g + kgain·e) / 256)). In this formula g is the current gain, pole and kgain are 8-bit unsigned values, and e = request − estimate is a signed difference of two 9-bit values.
- R3: The gain word is clamped to 0 when the update result is negative and to 255 when it is above 255.
- R4: The 2-bit averaging select sets how many estimates form one averaged value: 00 means 1, 01 means 2, 10 means 3 and 11 means 4. The average is sum, sum>>1, (sum·85)>>8 and sum>>2 respectively. The gain does not change until the group is complete.
- R5: With the 12-bit update decimation value D, the loop updates on the completion of every (D+1)-th averaged value, so the ratio ranges from 1 to 4096. The gain holds at all other times.
- R6: After reset, the first H accepted samples (H = 16-bit hold-off value) do not take part in averaging, decimation or gain updates.
- R7: An output sample is clamp16(((x·(16 + g[3:0])) << g[7:4]) >>> 4) for each of I and Q, using the gain held before that sample's own update. It appears one clock after the input, with out_valid following in_valid by one cycle.
- R8: While bypass is high, outputs equal the inputs one cycle later. Samples taken during bypass change neither the gain nor any loop state.
- R9: During reset the gain is 0 (unity scaling), and out_valid, out_i and out_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| cfg_request | input | 9 | Target level, log2 units with 4 fraction bits |
| cfg_kgain | input | 8 | Loop gain, value/256 |
| cfg_pole | input | 8 | Pole location, value/256 |
| cfg_avg_sel | input | 2 | Averaging count select (00 = 1 … 11 = 4) |
| cfg_update_dec | input | 12 | Update decimation minus one |
| cfg_holdoff | input | 16 | Samples ignored by the loop after reset |
| cfg_bypass | input | 1 | Pass samples unchanged and freeze the loop |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled in-phase output, signed |
| out_q | output | 16 | Scaled quadrature output, signed |
| gain_o | output | 8 | Current gain word, 4.4 log2 format |

## Verification
The bench targets several corner cases and the failure each one would expose:
- A zero-power input and the most negative I/Q pair. A wrong leading-one search or mantissa slice would give a wrong gain after a single update.
- Updates that overflow or underflow the gain range. Without clamping, the gain would wrap to a small or huge value.
- Incomplete averaging groups, decimation windows and hold-off windows. An off-by-one count would move the gain one sample early or late.
- Output scaling with a negative value and with full-scale values. These expose a missing sign extension or a missing 16-bit clamp.
- Bypass samples that would otherwise drive the gain somewhere new. A loop that is not frozen would leave a changed gain once bypass drops.

// File: rtl/agc_pkg.sv
package agc_pkg;
  parameter int SAMPLE_W  = 16;
  parameter int POW_W     = 2 * SAMPLE_W;
  parameter int MSB_W     = $clog2(POW_W);
  parameter int FRAC_W    = 4;
  parameter int LOG_W     = MSB_W + FRAC_W;
  parameter int AVG_SEL_W = 2;
  parameter int SUM_W     = LOG_W + AVG_SEL_W;
  parameter int GAIN_W    = 8;
  parameter int COEF_W    = 8;
  parameter int DEC_W     = 12;
  parameter int HOLD_W    = 16;
  parameter int LOOP_W    = LOG_W + 2 * COEF_W + 4;
  parameter int SCL_W     = SAMPLE_W + FRAC_W + 2 + (1 << (GAIN_W - FRAC_W));
  parameter int THIRD_MUL = 85;
  parameter int THIRD_SH  = 8;

  // Approximate log2 of the power: leading-one index plus linear mantissa
  function automatic logic [LOG_W-1:0] log2_approx(input logic [POW_W-1:0] p);
    logic [MSB_W-1:0] lead;
    logic [POW_W-1:0] norm;
    lead = '0;
    for (int b = 0; b < POW_W; b++) begin
      if (p[b]) lead = MSB_W'(b);
    end
    norm = p << (MSB_W'(POW_W - 1) - lead);
    if (p == '0) return '0;
    return {lead, norm[POW_W-2 -: FRAC_W]};
  endfunction

  // Divide a group sum by its size (1..4); a third uses a multiply-shift
  function automatic logic [LOG_W-1:0] avg_div(input logic [SUM_W-1:0] s,
                                               input logic [AVG_SEL_W-1:0] sel);
    logic [SUM_W+6:0] t;
    t = {7'b0, s} * (SUM_W+7)'(THIRD_MUL);
    case (sel)
      2'd0:    return LOG_W'(s);
      2'd1:    return LOG_W'(s >> 1);
      2'd2:    return LOG_W'(t >> THIRD_SH);
      default: return LOG_W'(s >> 2);
    endcase
  endfunction

  // One step of the first-order loop filter, clamped to the gain range
  function automatic logic [GAIN_W-1:0] loop_step(input logic [GAIN_W-1:0] g,
                                                  input logic [COEF_W-1:0] pole,
                                                  input logic [COEF_W-1:0] kg,
                                                  input logic [LOG_W-1:0]  req,
                                                  input logic [LOG_W-1:0]  est);
    logic signed [LOOP_W-1:0] gv, pv, kv, ev, acc, sh, top;
    gv  = $signed(LOOP_W'(g));
    pv  = $signed(LOOP_W'(pole));
    kv  = $signed(LOOP_W'(kg));
    ev  = $signed(LOOP_W'(req)) - $signed(LOOP_W'(est));
    acc = pv * gv + kv * ev;
    sh  = acc >>> COEF_W;
    top = $signed(LOOP_W'((1 << GAIN_W) - 1));
    if (sh < 0)   return '0;
    if (sh > top) return '1;
    return sh[GAIN_W-1:0];
  endfunction

  // Log-domain scaling: shift by integer part, multiply by (1 + fraction)
  function automatic logic signed [SAMPLE_W-1:0] scale_sample(
      input logic signed [SAMPLE_W-1:0] x, input logic [GAIN_W-1:0] g);
    logic signed [SCL_W-1:0] xe, m, prod, hi, lo;
    xe   = SCL_W'(x);
    m    = $signed(SCL_W'({1'b1, g[FRAC_W-1:0]}));
    prod = (xe * m) <<< g[GAIN_W-1:FRAC_W];
    prod = prod >>> FRAC_W;
    hi   = $signed(SCL_W'((1 << (SAMPLE_W - 1)) - 1));
    lo   = -hi - 1;
    if (prod > hi) return SAMPLE_W'(hi);
    if (prod < lo) return SAMPLE_W'(lo);
    return SAMPLE_W'(prod);
  endfunction
endpackage

// File: rtl/agc_power_log.sv
module agc_power_log
  import agc_pkg::*;
(
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic [LOG_W-1:0]           level_o
);
  logic signed [POW_W-1:0] sq_i, sq_q;
  logic [POW_W-1:0]        power;

  assign sq_i    = in_i * in_i;
  assign sq_q    = in_q * in_q;
  assign power   = $unsigned(sq_i) + $unsigned(sq_q);
  assign level_o = log2_approx(power);
endmodule

// File: rtl/agc_avg_dec.sv
module agc_avg_dec
  import agc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [LOG_W-1:0]     level,
  input  logic [AVG_SEL_W-1:0] avg_sel,
  input  logic [DEC_W-1:0]     update_dec,
  input  logic [HOLD_W-1:0]    holdoff,
  output logic                 update_o,
  output logic [LOG_W-1:0]     avg_o
);
  logic [HOLD_W-1:0]    hold_cnt;
  logic [AVG_SEL_W-1:0] grp_cnt;
  logic [SUM_W-1:0]     grp_sum;
  logic [DEC_W-1:0]     dec_cnt;
  logic                 in_hold, est_take, grp_done;
  logic [SUM_W-1:0]     sum_now;

  assign in_hold  = hold_cnt < holdoff;
  assign est_take = accept && !in_hold;
  assign grp_done = est_take && (grp_cnt >= avg_sel);
  assign sum_now  = grp_sum + SUM_W'(level);
  assign avg_o    = avg_div(sum_now, avg_sel);
  assign update_o = grp_done && (dec_cnt >= update_dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      grp_cnt  <= '0;
      grp_sum  <= '0;
      dec_cnt  <= '0;
    end else begin
      if (accept && in_hold) hold_cnt <= hold_cnt + 1'b1;
      if (est_take) begin
        if (grp_done) begin
          grp_cnt <= '0;
          grp_sum <= '0;
        end else begin
          grp_cnt <= grp_cnt + 1'b1;
          grp_sum <= sum_now;
        end
      end
      if (grp_done) dec_cnt <= update_o ? '0 : dec_cnt + 1'b1;
    end
  end

  assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> !update_o);
  assert_update_needs_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> accept);
  assert_group_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> (grp_cnt == '0));
endmodule

// File: rtl/agc_loop_filter.sv
module agc_loop_filter
  import agc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update,
  input  logic [LOG_W-1:0]  estimate,
  input  logic [LOG_W-1:0]  request,
  input  logic [COEF_W-1:0] kgain,
  input  logic [COEF_W-1:0] pole,
  output logic [GAIN_W-1:0] gain_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_o <= '0;
    else if (update) gain_o <= loop_step(gain_o, pole, kgain, request, estimate);
  end

  assert_gain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(gain_o));
endmodule

// File: rtl/agc_scaler.sv
module agc_scaler
  import agc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       bypass,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  input  logic [GAIN_W-1:0]          gain,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q
);
  logic signed [SAMPLE_W-1:0] sc_i, sc_q;

  assign sc_i = bypass ? in_i : scale_sample(in_i, gain);
  assign sc_q = bypass ? in_q : scale_sample(in_q, gain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= sc_i;
        out_q <= sc_q;
      end
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_bypass_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bypass) |=> (out_i == $past(in_i) && out_q == $past(in_q)));
endmodule

// File: rtl/agc_loop_ctrl.sv
module agc_loop_ctrl
  import agc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  input  logic [LOG_W-1:0]           cfg_request,
  input  logic [COEF_W-1:0]          cfg_kgain,
  input  logic [COEF_W-1:0]          cfg_pole,
  input  logic [AVG_SEL_W-1:0]       cfg_avg_sel,
  input  logic [DEC_W-1:0]           cfg_update_dec,
  input  logic [HOLD_W-1:0]          cfg_holdoff,
  input  logic                       cfg_bypass,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_i,
  output logic signed [SAMPLE_W-1:0] out_q,
  output logic [GAIN_W-1:0]          gain_o
);
  logic [LOG_W-1:0] level_w;
  logic [LOG_W-1:0] avg_w;
  logic             update_w;
  logic             accept_w;

  assign accept_w = in_valid && !cfg_bypass;

  agc_power_log u_pow (
    .in_i(in_i), .in_q(in_q), .level_o(level_w)
  );

  agc_avg_dec u_est (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .level(level_w),
    .avg_sel(cfg_avg_sel), .update_dec(cfg_update_dec), .holdoff(cfg_holdoff),
    .update_o(update_w), .avg_o(avg_w)
  );

  agc_loop_filter u_lf (
    .clk(clk), .rst_n(rst_n), .update(update_w), .estimate(avg_w),
    .request(cfg_request), .kgain(cfg_kgain), .pole(cfg_pole), .gain_o(gain_o)
  );

  agc_scaler u_scl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bypass(cfg_bypass),
    .in_i(in_i), .in_q(in_q), .gain(gain_o),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  assert_bypass_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass |=> $stable(gain_o));
endmodule

// File: tb/test_agc_loop_ctrl.sv
module test_agc_loop_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic [8:0]  cfg_request = '0;
  logic [7:0]  cfg_kgain = '0, cfg_pole = '0;
  logic [1:0]  cfg_avg_sel = '0;
  logic [11:0] cfg_update_dec = '0;
  logic [15:0] cfg_holdoff = '0;
  logic        cfg_bypass = 1'b0;
  logic        out_valid;
  logic signed [15:0] out_i, out_q;
  logic [7:0]  gain_o;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  agc_loop_ctrl i_agc_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_request(cfg_request), .cfg_kgain(cfg_kgain), .cfg_pole(cfg_pole),
    .cfg_avg_sel(cfg_avg_sel), .cfg_update_dec(cfg_update_dec),
    .cfg_holdoff(cfg_holdoff), .cfg_bypass(cfg_bypass),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .gain_o(gain_o)
  );

  // single-update vectors from reset: sample, request, kgain -> expected gain
  localparam int T_I   [6] = '{16, 0, 1000, -32768, 3, 0};
  localparam int T_Q   [6] = '{0, 0, 0, -32768, 4, 0};
  localparam int T_REQ [6] = '{200, 100, 100, 511, 300, 511};
  localparam int T_K   [6] = '{64, 128, 255, 255, 255, 255};
  localparam int T_EXP [6] = '{18, 50, 0, 14, 226, 255};

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic ck(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    cfg_request = '0; cfg_kgain = '0; cfg_pole = '0; cfg_avg_sel = '0;
    cfg_update_dec = '0; cfg_holdoff = '0; cfg_bypass = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input int si, input int sq);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 16'(si);
    in_q = 16'(sq);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // bench view of the output scaling rule
  function automatic int model_scale(input int x, input int g);
    longint p;
    p = (longint'(x) * (16 + (g % 16))) * (longint'(1) << (g / 16));
    p = p >>> 4;
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    ck("R9 gain in reset", gain_o, 0);
    ck("R9 out_valid in reset", out_valid, 0);
    ck("R9 out_i in reset", out_i, 0);

    // R1/R2/R3: table of single updates
    for (int r = 0; r < 6; r++) begin
      do_reset();
      cfg_request = 9'(T_REQ[r]);
      cfg_kgain   = 8'(T_K[r]);
      send(T_I[r], T_Q[r]);
      ck($sformatf("R1 R2 R3 vector %0d gain", r), gain_o, T_EXP[r]);
    end

    // R7: unity scaling right after reset, then gain 18
    do_reset();
    send(1234, -7);
    ck("R7 unity out_i", out_i, 1234);
    ck("R7 unity out_q", out_q, -7);
    ck("R7 out_valid", out_valid, 1);
    @(negedge clk);
    ck("R7 out_valid drops", out_valid, 0);
    cfg_request = 9'd200; cfg_kgain = 8'd64;
    send(16, 0);
    ck("R7 setup gain", gain_o, 18);
    cfg_update_dec = 12'd4095;
    send(1000, -1000);
    ck("R7 scaled out_i", out_i, model_scale(1000, 18));
    ck("R7 scaled out_q", out_q, model_scale(-1000, 18));
    send(30000, -30000);
    ck("R7 clamp high", out_i, 32767);
    ck("R7 clamp low", out_q, -32768);

    // R2: pole term alone
    cfg_update_dec = '0; cfg_kgain = '0; cfg_pole = 8'd128;
    send(0, 0);
    ck("R2 pole decay", gain_o, 9);

    // R4: averaging groups of 4, 3 and 2
    do_reset();
    cfg_request = 9'd200; cfg_kgain = 8'd64; cfg_avg_sel = 2'b11;
    send(16, 0); send(16, 0); send(0, 0);
    ck("R4 group of 4 incomplete", gain_o, 0);
    send(0, 0);
    ck("R4 group of 4 update", gain_o, 34);
    do_reset();
    cfg_request = 9'd200; cfg_kgain = 8'd64; cfg_avg_sel = 2'b10;
    send(16, 0); send(16, 0);
    ck("R4 group of 3 incomplete", gain_o, 0);
    send(0, 0);
    ck("R4 group of 3 update", gain_o, 28);
    do_reset();
    cfg_request = 9'd200; cfg_kgain = 8'd64; cfg_avg_sel = 2'b01;
    send(16, 0);
    ck("R4 group of 2 incomplete", gain_o, 0);
    send(0, 0);
    ck("R4 group of 2 update", gain_o, 34);

    // R5: decimation by 3
    do_reset();
    cfg_request = 9'd200; cfg_kgain = 8'd64; cfg_update_dec = 12'd2;
    send(16, 0); send(16, 0);
    ck("R5 decimated hold", gain_o, 0);
    send(16, 0);
    ck("R5 decimated update", gain_o, 18);

    // R6: hold-off of two samples
    do_reset();
    cfg_request = 9'd200; cfg_kgain = 8'd64; cfg_holdoff = 16'd2;
    send(16, 0); send(16, 0);
    ck("R6 hold-off ignores", gain_o, 0);
    send(16, 0);
    ck("R6 first counted sample", gain_o, 18);

    // R8: bypass passes samples and freezes the loop
    do_reset();
    cfg_request = 9'd200; cfg_kgain = 8'd64;
    send(16, 0);
    cfg_bypass = 1'b1;
    send(30000, -5);
    ck("R8 bypass out_i", out_i, 30000);
    ck("R8 bypass out_q", out_q, -5);
    send(0, 0); send(0, 0);
    cfg_bypass = 1'b0;
    @(negedge clk);
    ck("R8 gain frozen", gain_o, 18);

    // R9: reset mid-run clears the gain
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    ck("R9 gain after reset", gain_o, 0);
    ck("R9 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;

    finish_run();
  end
endmodule